// File: doc/BRIEF.md
# Collision-Vector Pipeline Issue Controller

This block decides, cycle by cycle, whether a new task may enter a nonlinear pipeline whose stage usage follows a fixed reservation table. At elaboration time the table is reduced to a set of forbidden latencies. A latency is forbidden when two marks in the same stage row lie that many cycles apart. At run time the block keeps a shifting collision vector that records which of the coming cycles would cause a stage conflict with tasks already in flight.

A request on `start_req_i` is granted in the same cycle, through `initiate_o`, whenever the lowest vector bit is clear. The issue policy is greedy: a waiting request starts at the earliest latency that causes no conflict. Requests are not queued. The current vector and a saturating count of cycles since the last initiation are exposed, so the greedy latency sequence can be observed from outside.

Top module: `pipe_issue_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it rises, `cv_o` is 0 and `since_last_o` is all ones (15 at the default width of 4). The first request after reset is granted in the same cycle.
- R2: The default reservation table has 4 stages and 6 time slots. Stage A is used at times 0, 1 and 5, stage B at times 2 and 3, stage C at time 4, and stage D at time 3. This gives the forbidden latencies {1, 4, 5}. The forbidden vector is 8'h19, where bit i-1 set means latency i is forbidden. After an initiation from the idle state (`cv_o` = 0), `cv_o` equals 8'h19 in the next cycle.
- R3: `initiate_o` is high in a cycle exactly when `start_req_i` is high and bit 0 of `cv_o` is 0. Consequently no two initiations ever need the same stage in the same cycle.
- R4: In the cycle after an initiation, `cv_o` equals the previous `cv_o` shifted one place toward bit 0, ORed with the forbidden vector.
- R5: In the cycle after a cycle without initiation, `cv_o` equals the previous `cv_o` shifted one place toward bit 0, with a 0 entering at the top bit. Once the idle time exceeds the longest forbidden latency, `cv_o` returns to 0.
- R6: `since_last_o` is 1 in the cycle after an initiation. It then rises by one each cycle and holds at its all-ones value.
- R7: If `start_req_i` is held high from reset with the default table, initiations occur at cycles 0, 2, 8, 10, 16 and so on. The latencies alternate between 2 and 6. When `initiate_o` is high, `since_last_o` shows the latency just taken.
- R8: While `start_req_i` is low, `initiate_o` stays low. A request that is dropped is not remembered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_req_i | input | 1 | A task wants to start this cycle |
| initiate_o | output | 1 | The task starts this cycle (combinational grant) |
| cv_o | output | N_LAT | Current collision vector; bit i-1 stands for latency i |
| since_last_o | output | CNT_W | Saturating count of cycles since the last initiation |

## Verification
The in-RTL assertions check, on every cycle, the following properties:
- A grant never falls at a forbidden latency relative to the last initiation.
- The forbidden bits are present after every initiation.
- An idle cycle never adds bits to the vector.
- The gap counter restarts at 1 on an initiation and holds at saturation.

Stage conflicts with initiations older than the last one are shown only by the bench. It replays every grant against a cycle-accurate stage occupancy model built from the table. The exact greedy latency pattern, the dropping of withdrawn requests, and the exact vector values after mixed idle and issue cycles are also shown only by the bench's scenarios.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int MAX_LAT = 8;
  localparam int MAX_TBL = 64;

  // Union over rows of all distances between marks in the same row.
  function automatic logic [MAX_LAT-1:0] forbidden_of(input logic [MAX_TBL-1:0] tbl,
                                                      input int stages, input int cols);
    logic [MAX_LAT-1:0] f;
    f = '0;
    for (int s = 0; s < stages; s++)
      for (int a = 0; a < cols; a++)
        for (int b = a + 1; b < cols; b++)
          if (tbl[s*cols+a] && tbl[s*cols+b] && (b - a) <= MAX_LAT)
            f[b-a-1] = 1'b1;
    return f;
  endfunction
endpackage

// File: rtl/pic_cv_state.sv
module pic_cv_state #(
  parameter int              N      = 8,
  parameter logic [N-1:0]    FORBID = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         issue_i,
  output logic [N-1:0] cv_o
);
  logic [N-1:0] cv_q, cv_d;

  always_comb begin
    cv_d = {1'b0, cv_q[N-1:1]};
    if (issue_i) cv_d = cv_d | FORBID;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cv_q <= '0;
    else         cv_q <= cv_d;

  assign cv_o = cv_q;

  assert_idle_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && cv_q == '0) |=> (cv_q == FORBID));
  assert_forbid_merged_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> ((cv_q & FORBID) == FORBID));
  assert_idle_no_growth_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> ($countones(cv_q) <= $countones($past(cv_q))));
endmodule

// File: rtl/pic_gap_cnt.sv
module pic_gap_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         issue_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] SAT = {W{1'b1}};
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (issue_i)           cnt_d = W'(1);
    else if (cnt_q == SAT) cnt_d = cnt_q;
    else                   cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= SAT;
    else         cnt_q <= cnt_d;

  assign cnt_o = cnt_q;

  assert_restart_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> (cnt_q == W'(1)));
  assert_saturate_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issue_i && cnt_q == SAT) |=> (cnt_q == SAT));
endmodule

// File: rtl/pipe_issue_ctrl.sv
module pipe_issue_ctrl
  import pic_pkg::*;
#(
  parameter int N_LAT  = 8,
  parameter int STAGES = 4,
  parameter int COLS   = 6,
  parameter int CNT_W  = 4,
  // bit s*COLS+t set: stage s busy t cycles after a task starts
  parameter logic [STAGES*COLS-1:0] RES_TBL = 24'b001000_010000_001100_100011
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_req_i,
  output logic             initiate_o,
  output logic [N_LAT-1:0] cv_o,
  output logic [CNT_W-1:0] since_last_o
);
  localparam logic [MAX_TBL-1:0] TBL_EXT = MAX_TBL'(RES_TBL);
  localparam logic [MAX_LAT-1:0] FORBID_FULL = forbidden_of(TBL_EXT, STAGES, COLS);
  localparam logic [N_LAT-1:0]   FORBID = N_LAT'(FORBID_FULL);

  logic [N_LAT-1:0] cv_w;
  logic [CNT_W-1:0] gap_w;

  assign initiate_o = start_req_i & ~cv_w[0];

  pic_cv_state #(.N(N_LAT), .FORBID(FORBID)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (initiate_o),
    .cv_o    (cv_w)
  );

  pic_gap_cnt #(.W(CNT_W)) u_gap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (initiate_o),
    .cnt_o   (gap_w)
  );

  assign cv_o         = cv_w;
  assign since_last_o = gap_w;

  // Is the gap since the last start itself a forbidden latency?
  logic gap_forbidden;
  always_comb begin
    gap_forbidden = 1'b0;
    for (int i = 1; i <= N_LAT; i++)
      if (int'(gap_w) == i) gap_forbidden = FORBID[i-1];
  end

  assert_no_forbidden_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    initiate_o |-> !gap_forbidden);
endmodule

// File: tb/tb_pipe_issue_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_issue_ctrl;
  localparam int STAGES = 4;
  localparam int COLS   = 6;
  localparam logic [STAGES*COLS-1:0] RT = 24'b001000_010000_001100_100011;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_req = 1'b0;
  logic       initiate;
  logic [7:0] cv;
  logic [3:0] gap;

  always #5 clk = ~clk;

  pipe_issue_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .start_req_i(start_req),
    .initiate_o(initiate), .cv_o(cv), .since_last_o(gap)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic occ [STAGES][COLS];
  logic       init_s;
  logic [7:0] cv_s;
  logic [3:0] gap_s;

  // {request, expected grant} per cycle from reset
  localparam logic [1:0] VEC [20] = '{
    2'b11, 2'b10, 2'b11, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b11, 2'b10,
    2'b11, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b10, 2'b11};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int s = 0; s < STAGES; s++)
      for (int t = 0; t < COLS; t++) occ[s][t] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start_req = 1'b0;
    clear_model();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic req);
    logic permit;
    @(negedge clk);
    start_req = req;
    #1;
    permit = 1'b1;
    for (int s = 0; s < STAGES; s++)
      for (int t = 0; t < COLS; t++)
        if (RT[s*COLS+t] && occ[s][t]) permit = 1'b0;
    init_s = initiate;
    cv_s   = cv;
    gap_s  = gap;
    chk(init_s == (req && permit), "R3 occupancy", init_s, req && permit);
    @(posedge clk);
    if (init_s)
      for (int s = 0; s < STAGES; s++)
        for (int t = 0; t < COLS; t++)
          if (RT[s*COLS+t]) occ[s][t] = 1'b1;
    for (int s = 0; s < STAGES; s++) begin
      for (int t = 0; t < COLS - 1; t++) occ[s][t] = occ[s][t+1];
      occ[s][COLS-1] = 1'b0;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clear_model();
    do_reset();
    #1;
    chk(cv == 8'h00, "R1 cv", cv, 8'h00);
    chk(gap == 4'hF, "R1 gap", gap, 4'hF);

    // greedy sequence, dropped requests, re-entry
    for (int i = 0; i < 20; i++) begin
      step(VEC[i][1]);
      if (VEC[i][1]) chk(init_s == VEC[i][0], "R7 greedy", init_s, VEC[i][0]);
      else           chk(init_s == 1'b0, "R8 no request", init_s, 0);
    end

    do_reset();
    step(1'b1);
    chk(init_s == 1'b1, "R1 first grant", init_s, 1);
    step(1'b0);
    chk(cv_s == 8'h19, "R2 forbidden vector", cv_s, 8'h19);
    chk(gap_s == 4'd1, "R6 gap one", gap_s, 1);
    step(1'b1);
    chk(cv_s == 8'h0C, "R5 shift", cv_s, 8'h0C);
    chk(init_s == 1'b1, "R7 latency 2 grant", init_s, 1);
    chk(gap_s == 4'd2, "R7 gap shows latency", gap_s, 2);
    step(1'b0);
    chk(cv_s == 8'h1F, "R4 merge", cv_s, 8'h1F);
    step(1'b0);
    chk(cv_s == 8'h0F, "R5 idle shift", cv_s, 8'h0F);
    repeat (20) step(1'b0);
    step(1'b0);
    chk(gap_s == 4'hF, "R6 saturate", gap_s, 4'hF);
    chk(cv_s == 8'h00, "R5 drained", cv_s, 8'h00);

    // reset mid-flight clears state
    step(1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    clear_model();
    #1;
    chk(cv == 8'h00, "R1 async clear", cv, 8'h00);
    chk(gap == 4'hF, "R1 async gap", gap, 4'hF);
    @(negedge clk);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule